// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block sits between the divider chain of a frequency synthesiser and its charge pump. A programmable divider divides the reference input by a ratio from 1 to 1023. A three-state phase-frequency detector then compares that divided reference against the divided RF pulse from the feedback chain. It drives up and down requests whose width is the phase error. A fixed two-cycle overlap at every comparison removes any dead band around zero phase error.

A sense bit reverses the loop polarity. It exchanges the two detector inputs and also exchanges which monitor output carries which divided signal. A two-bit mode selects whether the monitor outputs are active. It also selects whether the internal detector drives the pump: always, never, or only until lock is reported. A lock filter looks at the one-sided correction width in every reference period. It feeds a saturating integrator that declares lock slowly and withdraws it about three times faster. A pump-enable input models the programming strobe: while it is low the pump requests are silent and the reference divider is held cleared.

The detector state machine has states PD_IDLE, PD_UP, PD_DN, PD_OVL1 and PD_OVL2. PD_IDLE goes to PD_UP on a reference edge alone, to PD_DN on a feedback edge alone, and to PD_OVL1 when both edges arrive together. PD_UP goes to PD_OVL1 on a feedback edge, and PD_DN goes to PD_OVL1 on a reference edge. PD_OVL1 always goes to PD_OVL2, and PD_OVL2 always returns to PD_IDLE. Any state returns to PD_IDLE while pump enable is low. The lock filter has states LK_SEEK and LK_HELD. It moves from LK_SEEK to LK_HELD when the integrator reaches the upper threshold at a period judgement. It moves back from LK_HELD to LK_SEEK when the integrator falls to the lower threshold.

Top module: `pfd_lockdet`

## Requirements
- R1: Reset forces the outputs up, dn, mon_fb, mon_ref and lock low.
- R2: The divider lets through every Nth rising edge of ref_in, starting with the Nth after reset or after pump enable returns. N is ref_ratio, and a value of 0 acts as 1. The divided pulse is high for exactly the high time of that ref_in pulse, one clock later.
- R3: With sense 0, a divided reference edge leading the RF edge by d clocks gives up high for d+2 clocks and dn high for 2 clocks. An RF edge leading by d gives dn for d+2 clocks and up for 2 clocks.
- R4: Coincident edges drive both up and dn high for exactly 2 clocks, so there is no dead band.
- R5: With sense 1 the detector inputs are exchanged, so a leading reference produces the longer dn. The monitor outputs are also exchanged: mon_fb carries the divided reference and mon_ref carries the RF pulse.
- R6: Mode code st_code=00 holds mon_fb and mon_ref low. Codes 01, 10 and 11 pass the monitors. With sense 0, mon_fb follows rf_pulse delayed by one clock and mon_ref follows the divided reference.
- R7: Code 11 keeps up and dn low. Code 10 keeps up and dn low only while lock is high. Codes 00 and 01 let the detector drive.
- R8: While pump_en is low, up and dn are low and no divided reference pulse is produced.
- R9: At each divided reference edge, a period with at most 2 clocks of one-sided correction adds 1 to a 4-bit integrator that saturates at 15. Lock rises when the integrator reaches 12, so it takes 12 such periods from reset.
- R10: A period with more than 2 clocks of one-sided correction subtracts 3 from the integrator, with a floor at 0. Lock clears when the integrator reaches 3 or below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference input level, sampled on clk |
| rf_pulse | input | 1 | Divided RF pulse from the feedback divider |
| ref_ratio | input | 10 | Reference division ratio |
| sense | input | 1 | Loop polarity swap |
| st_code | input | 2 | Detector and monitor mode |
| pump_en | input | 1 | High lets the pump and divider run |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| mon_fb | output | 1 | Feedback monitor output |
| mon_ref | output | 1 | Reference monitor output |
| lock | output | 1 | Filtered lock indication |

## Verification
The hardest situation to reach from the ports is mode 10 after lock, where the detector must fall silent because of its own filtered history. The stimulus gets there with a long run of aligned reference and RF pulses until the integrator crosses its threshold. It then applies a small phase offset and shows that no pump activity appears. The asymmetric lock release is reached the same way: a lock is built up first, then a run of periods whose correction exceeds the tolerance is applied, and the bench counts the exact period at which lock drops.

// File: rtl/pfd_lockdet_pkg.sv
package pfd_lockdet_pkg;

    typedef enum logic [2:0] {
        PD_IDLE = 3'd0,
        PD_UP   = 3'd1,
        PD_DN   = 3'd2,
        PD_OVL1 = 3'd3,
        PD_OVL2 = 3'd4
    } pd_state_t;

    typedef enum logic {
        LK_SEEK = 1'b0,
        LK_HELD = 1'b1
    } lk_state_t;

    localparam logic [1:0] MODE_QUIET_MON = 2'b00;
    localparam logic [1:0] MODE_FULL      = 2'b01;
    localparam logic [1:0] MODE_AUTO_OFF  = 2'b10;
    localparam logic [1:0] MODE_EXT       = 2'b11;

endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int RW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [RW-1:0] ratio,
    input  logic          ref_in,
    output logic          div_pulse,
    output logic          div_edge
);

    logic          ref_q;
    logic [RW-1:0] cnt_q;
    logic [RW-1:0] lim;
    logic          rise;
    logic          term;

    always_comb begin
        lim  = (ratio == '0) ? RW'(1) : ratio;
        rise = ref_in & ~ref_q;
        term = (cnt_q >= (lim - RW'(1)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q     <= 1'b0;
            cnt_q     <= '0;
            div_pulse <= 1'b0;
            div_edge  <= 1'b0;
        end else begin
            ref_q <= ref_in;
            if (!run) begin
                cnt_q     <= '0;
                div_pulse <= 1'b0;
                div_edge  <= 1'b0;
            end else begin
                div_edge <= rise & term;
                if (rise) begin
                    cnt_q     <= term ? '0 : cnt_q + RW'(1);
                    div_pulse <= term;
                end else if (!ref_in) begin
                    div_pulse <= 1'b0;
                end
            end
        end
    end

    AST_PULSE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> ref_q); // R2

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rise && $stable(ratio)) |=> (cnt_q < lim || ratio != $past(ratio))); // R2

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_lockdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_e,
    input  logic fb_e,
    output logic up_raw,
    output logic dn_raw
);

    pd_state_t state_q;
    pd_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = PD_IDLE;
        end else begin
            unique case (state_q)
                PD_IDLE: begin
                    if (ref_e && fb_e) state_d = PD_OVL1;
                    else if (ref_e)    state_d = PD_UP;
                    else if (fb_e)     state_d = PD_DN;
                end
                PD_UP:   if (fb_e)  state_d = PD_OVL1;
                PD_DN:   if (ref_e) state_d = PD_OVL1;
                PD_OVL1: state_d = PD_OVL2;
                PD_OVL2: state_d = PD_IDLE;
                default: state_d = PD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        up_raw = 1'b0;
        dn_raw = 1'b0;
        unique case (state_q)
            PD_IDLE: ;
            PD_UP:   up_raw = 1'b1;
            PD_DN:   dn_raw = 1'b1;
            PD_OVL1: begin up_raw = 1'b1; dn_raw = 1'b1; end
            PD_OVL2: begin up_raw = 1'b1; dn_raw = 1'b1; end
            default: ;
        endcase
    end

    AST_ZERO_DEAD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ref_e && fb_e && state_q == PD_IDLE) |=> (up_raw && dn_raw)); // R4

    AST_OVERLAP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $rose(up_raw && dn_raw)) |=> (up_raw && dn_raw)); // R3

    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (!up_raw && !dn_raw)); // R8

endmodule

// File: rtl/lock_filter.sv
module lock_filter
    import pfd_lockdet_pkg::*;
#(
    parameter int INT_W   = 4,
    parameter int ERR_TOL = 2,
    parameter int LOCK_HI = 12,
    parameter int LOCK_LO = 3,
    parameter int DROP    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_raw,
    input  logic dn_raw,
    input  logic judge,
    output logic lock
);

    localparam int ERR_W = $clog2(ERR_TOL + 2);
    localparam logic [ERR_W-1:0] ERR_SAT = ERR_W'(ERR_TOL + 1);
    localparam logic [ERR_W-1:0] ERR_LIM = ERR_W'(ERR_TOL);
    localparam logic [INT_W-1:0] INT_TOP = '1;
    localparam logic [INT_W-1:0] DROP_V  = INT_W'(DROP);
    localparam logic [INT_W-1:0] HI_V    = INT_W'(LOCK_HI);
    localparam logic [INT_W-1:0] LO_V    = INT_W'(LOCK_LO);

    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_d;
    logic [INT_W-1:0] integ_q;
    logic [INT_W-1:0] integ_d;
    lk_state_t        lk_q;
    lk_state_t        lk_d;
    logic             one_sided;
    logic             good;

    always_comb begin
        one_sided = up_raw ^ dn_raw;
        good      = (err_q <= ERR_LIM);
        if (judge) begin
            err_d = one_sided ? ERR_W'(1) : '0;
        end else if (one_sided && err_q != ERR_SAT) begin
            err_d = err_q + ERR_W'(1);
        end else begin
            err_d = err_q;
        end
        integ_d = integ_q;
        if (judge) begin
            if (good) integ_d = (integ_q == INT_TOP) ? integ_q : integ_q + INT_W'(1);
            else      integ_d = (integ_q < DROP_V) ? '0 : integ_q - DROP_V;
        end
    end

    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_SEEK: if (judge && integ_d >= HI_V) lk_d = LK_HELD;
            LK_HELD: if (judge && integ_d <= LO_V) lk_d = LK_SEEK;
            default: lk_d = LK_SEEK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q    <= LK_SEEK;
            err_q   <= '0;
            integ_q <= '0;
        end else begin
            lk_q    <= lk_d;
            err_q   <= err_d;
            integ_q <= integ_d;
        end
    end

    always_comb lock = (lk_q == LK_HELD);

    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> (integ_q >= HI_V)); // R9

    AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> (integ_q <= LO_V)); // R10

    AST_INTEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!judge) |=> $stable(integ_q)); // R9

endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet
    import pfd_lockdet_pkg::*;
#(
    parameter int RW      = 10,
    parameter int INT_W   = 4,
    parameter int ERR_TOL = 2,
    parameter int LOCK_HI = 12,
    parameter int LOCK_LO = 3,
    parameter int DROP    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic          rf_pulse,
    input  logic [RW-1:0] ref_ratio,
    input  logic          sense,
    input  logic [1:0]    st_code,
    input  logic          pump_en,
    output logic          up,
    output logic          dn,
    output logic          mon_fb,
    output logic          mon_ref,
    output logic          lock
);

    logic div_pulse;
    logic div_edge;
    logic rf_q;
    logic rf_edge_q;
    logic ref_e;
    logic fb_e;
    logic up_raw;
    logic dn_raw;
    logic det_on;
    logic mon_en;

    ref_divider #(.RW(RW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (pump_en),
        .ratio     (ref_ratio),
        .ref_in    (ref_in),
        .div_pulse (div_pulse),
        .div_edge  (div_edge)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q      <= 1'b0;
            rf_edge_q <= 1'b0;
        end else begin
            rf_q      <= rf_pulse;
            rf_edge_q <= rf_pulse & ~rf_q;
        end
    end

    always_comb begin
        ref_e = sense ? rf_edge_q : div_edge;
        fb_e  = sense ? div_edge  : rf_edge_q;
    end

    pfd_core u_pfd (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (pump_en),
        .ref_e  (ref_e),
        .fb_e   (fb_e),
        .up_raw (up_raw),
        .dn_raw (dn_raw)
    );

    lock_filter #(
        .INT_W   (INT_W),
        .ERR_TOL (ERR_TOL),
        .LOCK_HI (LOCK_HI),
        .LOCK_LO (LOCK_LO),
        .DROP    (DROP)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .up_raw (up_raw),
        .dn_raw (dn_raw),
        .judge  (div_edge),
        .lock   (lock)
    );

    always_comb begin
        det_on = pump_en;
        unique case (st_code)
            MODE_QUIET_MON: ;
            MODE_FULL:      ;
            MODE_AUTO_OFF:  if (lock) det_on = 1'b0;
            MODE_EXT:       det_on = 1'b0;
            default:        det_on = 1'b0;
        endcase
        mon_en  = (st_code != MODE_QUIET_MON);
        up      = up_raw & det_on;
        dn      = dn_raw & det_on;
        mon_fb  = mon_en & (sense ? div_pulse : rf_q);
        mon_ref = mon_en & (sense ? rf_q : div_pulse);
    end

    AST_EXT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == MODE_EXT) |-> (!up && !dn)); // R7

    AST_MON_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == MODE_QUIET_MON) |-> (!mon_fb && !mon_ref)); // R6

    AST_NO_DIV_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_en) |=> (!div_pulse)); // R8

endmodule

// File: tb/sim_pfd_lockdet.sv
module sim_pfd_lockdet;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_in;
    logic       rf_pulse;
    logic [9:0] ref_ratio;
    logic       sense;
    logic [1:0] st_code;
    logic       pump_en;
    logic       up, dn, mon_fb, mon_ref, lock;

    int nvec = 0;
    int nbad = 0;
    int c_up, c_dn, c_mf, c_mr;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pfd_lockdet u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rf_pulse(rf_pulse),
        .ref_ratio(ref_ratio), .sense(sense), .st_code(st_code), .pump_en(pump_en),
        .up(up), .dn(dn), .mon_fb(mon_fb), .mon_ref(mon_ref), .lock(lock)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        c_up = 0; c_dn = 0; c_mf = 0; c_mr = 0;
    endtask

    task automatic step(input logic r, input logic f);
        @(negedge clk);
        c_up += int'(up); c_dn += int'(dn); c_mf += int'(mon_fb); c_mr += int'(mon_ref);
        ref_in = r; rf_pulse = f;
    endtask

    task automatic period(input int p, input int dr, input int hr, input int df, input int hf);
        for (int i = 0; i < p; i++)
            step(i >= dr && i < dr + hr, i >= df && i < df + hf);
    endtask

    task automatic do_reset(input logic [9:0] ratio, input logic s, input logic [1:0] code);
        ref_ratio = ratio; sense = s; st_code = code; pump_en = 1'b1;
        rst_n = 1'b0; ref_in = 1'b0; rf_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr();
    endtask

    task automatic t_reset();
        do_reset(10'd1, 1'b0, 2'b01);
        chk("R1 up", int'(up), 0);
        chk("R1 dn", int'(dn), 0);
        chk("R1 lock", int'(lock), 0);
        chk("R1 mon", int'(mon_fb | mon_ref), 0);
    endtask

    task automatic t_phase();
        do_reset(10'd1, 1'b0, 2'b01);
        period(16, 0, 2, 3, 5);
        chk("R3 ref lead up", c_up, 5);
        chk("R3 ref lead dn", c_dn, 2);
        chk("R6 mon_fb width", c_mf, 5);
        chk("R6 mon_ref width", c_mr, 2);
        do_reset(10'd1, 1'b0, 2'b01);
        period(16, 4, 2, 0, 2);
        chk("R3 rf lead dn", c_dn, 6);
        chk("R3 rf lead up", c_up, 2);
        do_reset(10'd1, 1'b0, 2'b01);
        period(16, 0, 2, 0, 2);
        chk("R4 coincident up", c_up, 2);
        chk("R4 coincident dn", c_dn, 2);
    endtask

    task automatic t_sense();
        do_reset(10'd1, 1'b1, 2'b01);
        period(16, 0, 2, 3, 5);
        chk("R5 swapped up", c_up, 2);
        chk("R5 swapped dn", c_dn, 5);
        chk("R5 mon_fb carries ref", c_mf, 2);
        chk("R5 mon_ref carries rf", c_mr, 5);
    endtask

    task automatic t_modes();
        do_reset(10'd1, 1'b0, 2'b00);
        period(16, 0, 2, 3, 5);
        chk("R6 code00 monitors", c_mf + c_mr, 0);
        chk("R7 code00 up", c_up, 5);
        do_reset(10'd1, 1'b0, 2'b11);
        period(16, 0, 2, 3, 5);
        chk("R7 code11 pump", c_up + c_dn, 0);
        chk("R6 code11 mon_ref", c_mr, 2);
    endtask

    task automatic t_auto_off();
        do_reset(10'd1, 1'b0, 2'b10);
        period(10, 0, 2, 0, 2);
        chk("R7 code10 unlocked up", c_up, 2);
        repeat (12) period(10, 0, 2, 0, 2);
        chk("R9 lock in code10", int'(lock), 1);
        clr();
        period(10, 0, 2, 2, 2);
        chk("R7 code10 locked pump", c_up + c_dn, 0);
        chk("R7 code10 mon_ref", c_mr, 2);
    endtask

    task automatic t_pump();
        do_reset(10'd1, 1'b0, 2'b01);
        pump_en = 1'b0;
        period(16, 0, 2, 3, 2);
        chk("R8 pump off", c_up + c_dn, 0);
        chk("R8 divider held", c_mr, 0);
        pump_en = 1'b1;
        clr();
        period(16, 0, 2, 3, 2);
        chk("R8 pump back up", c_up, 5);
    endtask

    task automatic t_divider();
        do_reset(10'd3, 1'b0, 2'b01);
        repeat (9) period(6, 0, 2, 0, 0);
        chk("R2 ratio3 width2", c_mr, 6);
        do_reset(10'd3, 1'b0, 2'b01);
        repeat (9) period(6, 0, 3, 0, 0);
        chk("R2 ratio3 width3", c_mr, 9);
        do_reset(10'd0, 1'b0, 2'b01);
        repeat (9) period(6, 0, 2, 0, 0);
        chk("R2 ratio0 as 1", c_mr, 18);
        do_reset(10'd1023, 1'b0, 2'b01);
        repeat (1022) period(4, 0, 2, 0, 0);
        chk("R2 ratio1023 before", c_mr, 0);
        period(4, 0, 2, 0, 0);
        chk("R2 ratio1023 at", c_mr, 2);
    endtask

    task automatic t_lock();
        do_reset(10'd1, 1'b0, 2'b01);
        repeat (11) period(10, 0, 2, 0, 2);
        chk("R9 lock after 11", int'(lock), 0);
        period(10, 0, 2, 0, 2);
        chk("R9 lock after 12", int'(lock), 1);
        repeat (4) period(10, 0, 2, 5, 2);
        chk("R10 lock after 4 bad", int'(lock), 1);
        period(10, 0, 2, 5, 2);
        chk("R10 lock after 5 bad", int'(lock), 0);
        do_reset(10'd1, 1'b0, 2'b01);
        repeat (12) period(10, 0, 2, 2, 2);
        chk("R9 tolerance 2 good", int'(lock), 1);
    endtask

    initial begin
        t_reset();
        t_phase();
        t_sense();
        t_modes();
        t_auto_off();
        t_pump();
        t_divider();
        t_lock();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule